// File: doc/BRIEF.md
# Multiply-Divide Unit with Split HI/LO Accumulator

This block is a sequential arithmetic unit for a processor datapath that holds a 64-bit accumulator. The accumulator is split into a low word (LO, bits 31:0) and a high word (HI, bits 63:32). It can load a full product into the accumulator, add a product to it or subtract a product from it, in signed or unsigned form. It divides with the quotient landing in LO and the remainder in HI. It also moves a word into either half, reads either half out, and runs a three-operand multiply whose low product word goes only to the result port.

A caller raises `start_i` for one cycle with an operation code and two operands. Every operation except divide completes in a single cycle: `done_o` pulses on the cycle after the start, and `busy_o` stays low. A divide produces one quotient bit per cycle, so `busy_o` stays high for 32 cycles, and `done_o` pulses in the cycle in which `busy_o` falls. While the unit is busy, any start is dropped. The read port `result_o` is registered. It changes only on a read of HI or LO or on a three-operand multiply, and it holds its value otherwise.

Top module: `hilo_mdu`

## Requirements
- R1: After reset, HI, LO and `result_o` are zero, and `busy_o` and `done_o` are low.
- R2: Op code 0 (signed multiply) writes the full 64-bit signed product of `opa_i` and `opb_i` into {HI, LO}.
- R3: Op code 1 (unsigned multiply) writes the full 64-bit unsigned product into {HI, LO}.
- R4: Op codes 2 (signed) and 3 (unsigned) add the 64-bit product to {HI, LO}, modulo 2^64.
- R5: Op codes 4 (signed) and 5 (unsigned) subtract the 64-bit product from {HI, LO}, modulo 2^64.
- R6: Op code 12 places the low 32 bits of the signed product on `result_o` and leaves HI and LO unchanged.
- R7: Op codes 8 and 9 copy `opa_i` into HI and into LO respectively. Op codes 10 and 11 return HI and LO respectively on `result_o`.
- R8: For every op code other than 6 and 7, `done_o` pulses for one cycle on the cycle after the accepted start, and `busy_o` stays low.
- R9: Op code 7 (unsigned divide) puts the quotient in LO and the remainder in HI. `busy_o` is high for exactly 32 cycles after the start, and `done_o` pulses in the first cycle after `busy_o` falls.
- R10: Op code 6 (signed divide) truncates the quotient toward zero and gives the remainder the sign of the dividend. Its timing matches R9, and 0x80000000 divided by 0xFFFFFFFF gives quotient 0x80000000 and remainder 0.
- R11: A divide by zero, signed or unsigned, leaves LO = 0xFFFFFFFF and HI = the dividend, with the R9 timing and no error indication.
- R12: A start raised while `busy_o` is high is ignored. It does not change HI, LO or `result_o`, and it produces no extra `done_o` pulse.
- R13: Op codes 13 to 15 pulse `done_o` as in R8 and change neither HI, LO nor `result_o`. For all ops except 10, 11 and 12, `result_o` holds its prior value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin an operation |
| op_i | input | 4 | Operation code, sampled with `start_i` |
| opa_i | input | 32 | First operand (multiplicand, dividend, or value moved to HI/LO) |
| opb_i | input | 32 | Second operand (multiplier or divisor) |
| busy_o | output | 1 | High while a divide is iterating |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 32 | Registered read result for HI/LO reads and the three-operand multiply |

## Verification
Single-cycle operations must show `done_o` at the first sample after the start edge. A divide must show `busy_o` at 32 consecutive samples and `done_o` at the 33rd. The driver drives each start on a falling edge and counts the falling edges until `done_o`, and it checks both that count and the number of busy samples against these figures. The scoreboard pairs each completion with the value of `result_o` that a reference model of the accumulator predicts. Accumulator contents are checked through read operations issued after each update, so every check uses only the ports. A start injected in the middle of a divide has no queued item, so a stray completion or a corrupted LO is reported.

// File: rtl/hilo_mdu_pkg.sv
// Package: operation codes and accumulator update modes shared by the
// multiply-divide unit and its submodules.
package hilo_mdu_pkg;

    // Operation codes presented on op_i; values 13..15 are treated as no-ops.
    typedef enum logic [3:0] {
        OP_MULS  = 4'd0,
        OP_MULU  = 4'd1,
        OP_MADDS = 4'd2,
        OP_MADDU = 4'd3,
        OP_MSUBS = 4'd4,
        OP_MSUBU = 4'd5,
        OP_DIVS  = 4'd6,
        OP_DIVU  = 4'd7,
        OP_SETHI = 4'd8,
        OP_SETLO = 4'd9,
        OP_GETHI = 4'd10,
        OP_GETLO = 4'd11,
        OP_MUL3  = 4'd12,
        OP_RSV13 = 4'd13,
        OP_RSV14 = 4'd14,
        OP_RSV15 = 4'd15
    } mdu_op_e;

    // How the accumulator is updated on a clock edge.
    typedef enum logic [1:0] {
        ACC_HOLD = 2'd0,
        ACC_LOAD = 2'd1,
        ACC_ADD  = 2'd2,
        ACC_SUB  = 2'd3
    } acc_mode_e;

endpackage

// File: rtl/hilo_mdu_mult.sv
// Single-cycle multiplier producing the full double-width product.
// Assumes: both operands share one signedness, selected by signed_i.
// The operands are extended to double width, so the truncated product
// is the correct two's-complement result in both modes.
module hilo_mdu_mult #(
    parameter int W = 32
) (
    input  logic [W-1:0]   a_i,
    input  logic [W-1:0]   b_i,
    input  logic           signed_i,
    output logic [2*W-1:0] prod_o
);

    logic [2*W-1:0] ext_a;
    logic [2*W-1:0] ext_b;

    // Extend each operand by sign or by zero, then form the product.
    always_comb begin
        ext_a  = signed_i ? {{W{a_i[W-1]}}, a_i} : {{W{1'b0}}, a_i};
        ext_b  = signed_i ? {{W{b_i[W-1]}}, b_i} : {{W{1'b0}}, b_i};
        prod_o = ext_a * ext_b;
    end

endmodule

// File: rtl/hilo_mdu_div.sv
// Iterative restoring divider: one quotient bit per cycle, W cycles in total.
// Assumes: load_i is raised only while busy_o is low.
// fin_o is high during the final iteration cycle, and quo_o/rem_o then carry
// the finished, sign-corrected results for the caller to capture on that edge.
// A zero divisor yields an all-ones quotient and the raw dividend as remainder.
module hilo_mdu_div #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic         signed_i,
    input  logic [W-1:0] dividend_i,
    input  logic [W-1:0] divisor_i,
    output logic         busy_o,
    output logic         fin_o,
    output logic [W-1:0] quo_o,
    output logic [W-1:0] rem_o
);

    localparam int CW = $clog2(W + 1);

    logic [CW-1:0] cnt_q;
    logic [W-1:0]  rem_q, dq_q, dvs_q, orig_q;
    logic          negq_q, negr_q, zero_q;

    logic [W-1:0]  mag_a, mag_b;
    logic [W:0]    shifted, diff;
    logic          take;
    logic [W-1:0]  rem_nx, dq_nx;

    // Operand magnitudes for the signed form.
    always_comb begin
        mag_a = (signed_i && dividend_i[W-1]) ? -dividend_i : dividend_i;
        mag_b = (signed_i && divisor_i[W-1])  ? -divisor_i  : divisor_i;
    end

    // One restoring step: shift in a dividend bit and try a subtraction.
    always_comb begin
        shifted = {rem_q, dq_q[W-1]};
        diff    = shifted - {1'b0, dvs_q};
        take    = ~diff[W];
        rem_nx  = take ? diff[W-1:0] : shifted[W-1:0];
        dq_nx   = {dq_q[W-2:0], take};
    end

    // Iteration state: load operands, then step once per cycle until the count runs out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            rem_q  <= '0;
            dq_q   <= '0;
            dvs_q  <= '0;
            orig_q <= '0;
            negq_q <= 1'b0;
            negr_q <= 1'b0;
            zero_q <= 1'b0;
        end else if (load_i) begin
            cnt_q  <= CW'(W);
            rem_q  <= '0;
            dq_q   <= mag_a;
            dvs_q  <= mag_b;
            orig_q <= dividend_i;
            negq_q <= signed_i && (dividend_i[W-1] ^ divisor_i[W-1]);
            negr_q <= signed_i && dividend_i[W-1];
            zero_q <= (divisor_i == '0);
        end else if (busy_o) begin
            cnt_q <= cnt_q - CW'(1);
            rem_q <= rem_nx;
            dq_q  <= dq_nx;
        end
    end

    // Status and final results; the sign correction is applied on the last step.
    always_comb begin
        busy_o = (cnt_q != '0);
        fin_o  = (cnt_q == CW'(1));
        quo_o  = zero_q ? '1     : (negq_q ? -dq_nx  : dq_nx);
        rem_o  = zero_q ? orig_q : (negr_q ? -rem_nx : rem_nx);
    end

endmodule

// File: rtl/hilo_mdu_acc.sv
// Double-width accumulator holding the HI (upper) and LO (lower) words.
// Assumes: at most one update mode per cycle. A load writes only the halves
// enabled in half_we_i ({HI, LO}); add and subtract act on the full width.
module hilo_mdu_acc #(
    parameter int W = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  hilo_mdu_pkg::acc_mode_e mode_i,
    input  logic [1:0]             half_we_i,
    input  logic [2*W-1:0]         opnd_i,
    output logic [W-1:0]           hi_o,
    output logic [W-1:0]           lo_o
);
    import hilo_mdu_pkg::*;

    logic [2*W-1:0] acc_q;

    // Accumulator update: hold, partial load, add or subtract.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else begin
            case (mode_i)
                ACC_LOAD: begin
                    if (half_we_i[1]) acc_q[2*W-1:W] <= opnd_i[2*W-1:W];
                    if (half_we_i[0]) acc_q[W-1:0]   <= opnd_i[W-1:0];
                end
                ACC_ADD:  acc_q <= acc_q + opnd_i;
                ACC_SUB:  acc_q <= acc_q - opnd_i;
                default:  acc_q <= acc_q;
            endcase
        end
    end

    // Split view of the accumulator.
    always_comb begin
        hi_o = acc_q[2*W-1:W];
        lo_o = acc_q[W-1:0];
    end

endmodule

// File: rtl/hilo_mdu.sv
// Multiply-divide unit top level: decodes the operation and steers the
// multiplier and divider results into the HI/LO accumulator or the result register.
// Assumes: start_i is a one-cycle request. Starts that arrive while a divide
// is iterating are dropped. The divider's final write has priority over decode.
module hilo_mdu #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [3:0]   op_i,
    input  logic [W-1:0] opa_i,
    input  logic [W-1:0] opb_i,
    output logic         busy_o,
    output logic         done_o,
    output logic [W-1:0] result_o
);
    import hilo_mdu_pkg::*;

    mdu_op_e        op;
    logic           accept;
    logic           mul_signed;
    logic [2*W-1:0] prod;
    logic           div_busy, div_fin, div_load, div_signed;
    logic [W-1:0]   div_quo, div_rem;
    acc_mode_e      acc_mode;
    logic [1:0]     acc_we;
    logic [2*W-1:0] acc_opnd;
    logic [W-1:0]   hi_q, lo_q;
    logic           rd_en;
    logic [W-1:0]   rd_val;
    logic           done_q;
    logic [W-1:0]   result_q;

    // Request qualification and multiplier signedness.
    always_comb begin
        op         = mdu_op_e'(op_i);
        accept     = start_i && !div_busy;
        mul_signed = !(op == OP_MULU || op == OP_MADDU || op == OP_MSUBU);
        div_signed = (op == OP_DIVS);
        div_load   = accept && (op == OP_DIVS || op == OP_DIVU);
    end

    hilo_mdu_mult #(.W(W)) u_mult (
        .a_i      (opa_i),
        .b_i      (opb_i),
        .signed_i (mul_signed),
        .prod_o   (prod)
    );

    hilo_mdu_div #(.W(W)) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (div_load),
        .signed_i   (div_signed),
        .dividend_i (opa_i),
        .divisor_i  (opb_i),
        .busy_o     (div_busy),
        .fin_o      (div_fin),
        .quo_o      (div_quo),
        .rem_o      (div_rem)
    );

    // Decode: choose the accumulator update and the value for the read port.
    always_comb begin
        acc_mode = ACC_HOLD;
        acc_we   = 2'b11;
        acc_opnd = prod;
        rd_en    = 1'b0;
        rd_val   = hi_q;
        if (div_fin) begin
            acc_mode = ACC_LOAD;
            acc_opnd = {div_rem, div_quo};
        end else if (accept) begin
            case (op)
                OP_MULS, OP_MULU:   acc_mode = ACC_LOAD;
                OP_MADDS, OP_MADDU: acc_mode = ACC_ADD;
                OP_MSUBS, OP_MSUBU: acc_mode = ACC_SUB;
                OP_SETHI: begin
                    acc_mode = ACC_LOAD;
                    acc_we   = 2'b10;
                    acc_opnd = {opa_i, opa_i};
                end
                OP_SETLO: begin
                    acc_mode = ACC_LOAD;
                    acc_we   = 2'b01;
                    acc_opnd = {opa_i, opa_i};
                end
                OP_GETHI: begin
                    rd_en  = 1'b1;
                    rd_val = hi_q;
                end
                OP_GETLO: begin
                    rd_en  = 1'b1;
                    rd_val = lo_q;
                end
                OP_MUL3: begin
                    rd_en  = 1'b1;
                    rd_val = prod[W-1:0];
                end
                default: acc_mode = ACC_HOLD;
            endcase
        end
    end

    hilo_mdu_acc #(.W(W)) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_i    (acc_mode),
        .half_we_i (acc_we),
        .opnd_i    (acc_opnd),
        .hi_o      (hi_q),
        .lo_o      (lo_q)
    );

    // Completion pulse and registered read result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q   <= 1'b0;
            result_q <= '0;
        end else begin
            done_q <= (accept && !div_load) || div_fin;
            if (rd_en) result_q <= rd_val;
        end
    end

    // Output drive.
    always_comb begin
        busy_o   = div_busy;
        done_o   = done_q;
        result_o = result_q;
    end

endmodule

// File: rtl/hilo_mdu_chk.sv
// Checker for hilo_mdu: handshake timing, divide latency, and freezing of
// state while a divide is running. Attached to every hilo_mdu by bind.
module hilo_mdu_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start_i,
    input logic [3:0]   op_i,
    input logic         busy_o,
    input logic         done_o,
    input logic [W-1:0] result_o,
    input logic [W-1:0] hi_q,
    input logic [W-1:0] lo_q
);

    logic [15:0] busy_len;

    // Count consecutive busy cycles so the divide window is checked without a long $past.
    always_ff @(posedge clk) begin
        if (!rst_n)      busy_len <= '0;
        else if (busy_o) busy_len <= busy_len + 16'd1;
        else             busy_len <= '0;
    end

    AST_SINGLE_CYCLE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && op_i != 4'd6 && op_i != 4'd7) |=> (done_o && !busy_o)); // R8

    AST_DIV_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && (op_i == 4'd6 || op_i == 4'd7)) |=> (busy_o && !done_o)); // R9

    AST_DIV_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (done_o && busy_len == 16'(W))); // R9

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o); // R12

    AST_FROZEN_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> (!busy_o || ($stable(hi_q) && $stable(lo_q) && $stable(result_o)))); // R12

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_i && !busy_o && (op_i == 4'd10 || op_i == 4'd11 || op_i == 4'd12))
        |=> $stable(result_o)); // R13

endmodule

bind hilo_mdu hilo_mdu_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .op_i     (op_i),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .result_o (result_o),
    .hi_q     (hi_q),
    .lo_q     (lo_q)
);

// File: tb/hilo_mdu_bench.sv
// Scoreboard bench for hilo_mdu: the driver models HI/LO and the result
// register and queues the expected result; the monitor compares on each done.
module hilo_mdu_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [3:0]  op_i = '0;
    logic [31:0] opa_i = '0;
    logic [31:0] opb_i = '0;
    logic        busy_o, done_o;
    logic [31:0] result_o;

    int checks = 0;
    int errors = 0;
    bit ended  = 1'b0;

    logic [31:0] m_hi = '0, m_lo = '0, m_res = '0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;

    hilo_mdu u_hilo_mdu (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
        .opa_i(opa_i), .opb_i(opb_i), .busy_o(busy_o), .done_o(done_o),
        .result_o(result_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: pop one expected item per completion and compare result_o.
    always @(negedge clk) begin
        if (rst_n && done_o) begin
            if (exp_q.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R12: actual unexpected done expected none");
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, result_o, e);
            end
        end
    end

    // Driver: update the model, queue the expectation, pulse start, check timing.
    task automatic issue(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                         input string tag, input bit poke);
        longint      sa, sb;
        logic [63:0] ps, pu, acc, tmp;
        bit          is_div;
        int          lat, nbusy;
        sa  = longint'($signed(a));
        sb  = longint'($signed(b));
        ps  = 64'(sa * sb);
        pu  = {32'b0, a} * {32'b0, b};
        acc = {m_hi, m_lo};
        is_div = (op == 4'd6 || op == 4'd7);
        case (op)
            4'd0: acc = ps;
            4'd1: acc = pu;
            4'd2: acc = acc + ps;
            4'd3: acc = acc + pu;
            4'd4: acc = acc - ps;
            4'd5: acc = acc - pu;
            4'd6, 4'd7: begin
                if (b == 32'd0) acc = {a, 32'hFFFF_FFFF};
                else if (op == 4'd6) begin
                    tmp = 64'(sa / sb);
                    acc[31:0] = tmp[31:0];
                    tmp = 64'(sa % sb);
                    acc[63:32] = tmp[31:0];
                end else acc = {a % b, a / b};
            end
            4'd8:  acc[63:32] = a;
            4'd9:  acc[31:0]  = a;
            4'd10: m_res = m_hi;
            4'd11: m_res = m_lo;
            4'd12: m_res = ps[31:0];
            default: ;
        endcase
        {m_hi, m_lo} = acc;
        exp_q.push_back(m_res);
        tag_q.push_back(tag);
        start_i = 1'b1; op_i = op; opa_i = a; opb_i = b;
        @(negedge clk);
        start_i = 1'b0;
        lat = 1; nbusy = 0;
        while (!done_o && lat < 100) begin
            if (busy_o) nbusy++;
            if (poke && lat == 5) begin
                start_i = 1'b1; op_i = 4'd9; opa_i = 32'hDEAD_BEEF;
            end
            if (poke && lat == 6) begin
                start_i = 1'b1; op_i = 4'd10;
            end
            if (poke && lat == 7) start_i = 1'b0;
            @(negedge clk);
            lat++;
        end
        start_i = 1'b0;
        check(is_div ? "R9 latency" : "R8 latency", 32'(lat), is_div ? 32'd33 : 32'd1);
        check(is_div ? "R9 busy cycles" : "R8 busy cycles", 32'(nbusy), is_div ? 32'd32 : 32'd0);
    endtask

    task automatic read_back(input string tag);
        issue(4'd10, '0, '0, tag, 1'b0);
        issue(4'd11, '0, '0, tag, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 busy", 32'(busy_o), 32'd0);
        check("R1 done", 32'(done_o), 32'd0);
        check("R1 result", result_o, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        read_back("R1");

        issue(4'd0, 32'hFFFF_FFFE, 32'd3, "R2", 0);              read_back("R2");
        issue(4'd0, 32'h8000_0000, 32'h8000_0000, "R2", 0);      read_back("R2");
        issue(4'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R3", 0);      read_back("R3");

        issue(4'd8, 32'h0000_0001, '0, "R7", 0);
        issue(4'd9, 32'hFFFF_FFF0, '0, "R7", 0);                 read_back("R7");
        issue(4'd2, 32'hFFFF_FFFF, 32'd5, "R4", 0);              read_back("R4");
        issue(4'd3, 32'hFFFF_FFFF, 32'd2, "R4", 0);              read_back("R4");
        issue(4'd4, 32'h0001_0000, 32'hFFFF_0000, "R5", 0);      read_back("R5");
        issue(4'd5, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R5", 0);      read_back("R5");

        issue(4'd12, 32'hFFFF_FFF9, 32'd6, "R6", 0);
        issue(4'd12, 32'h1234_5678, 32'h9ABC_DEF0, "R6", 0);     read_back("R6");

        issue(4'd7, 32'd100, 32'd7, "R9", 0);                    read_back("R9");
        issue(4'd7, 32'hFFFF_FFFF, 32'd1, "R9", 0);              read_back("R9");
        issue(4'd6, 32'hFFFF_FFF9, 32'd2, "R10", 0);             read_back("R10");
        issue(4'd6, 32'd7, 32'hFFFF_FFFE, "R10", 0);             read_back("R10");
        issue(4'd6, 32'h8000_0000, 32'hFFFF_FFFF, "R10", 0);     read_back("R10");
        issue(4'd7, 32'h0000_ABCD, 32'd0, "R11", 0);             read_back("R11");
        issue(4'd6, 32'hFFFF_FF00, 32'd0, "R11", 0);             read_back("R11");

        issue(4'd7, 32'd1000, 32'd33, "R12", 1);                 read_back("R12");

        issue(4'd13, 32'h5555_5555, 32'd9, "R13", 0);
        issue(4'd15, 32'h1111_1111, 32'd2, "R13", 0);            read_back("R13");

        repeat (3) @(negedge clk);
        check("R12 pending completions", 32'(exp_q.size()), 32'd0);
        ended = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(20 * 200000);
        if (!ended) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule